// File: doc/BRIEF.md
# Receive Buffer Chaining Manager

This block stores incoming frames in a pool of small fixed-size buffers. When a frame starts, the block takes a buffer index from an internal free list and writes the frame bytes into it through a simple memory write port. When that buffer is full and more bytes arrive, the block takes the next free index, records the link from the full buffer to the new one in a link table, and carries on writing there. A frame can therefore be much longer than one buffer.

When a frame ends cleanly, the block marks the final buffer as the last one, records how many bytes it holds, and pushes a completion entry onto a queue. The entry holds the first buffer index and the total frame length. The consumer reads the chain through the link read port, pops the queue entry, and hands the buffers back one index per cycle.

When a frame ends with an error, or the pool runs dry in the middle of a frame, or the completion queue is full at end of frame, the block returns every buffer of that frame to the free list by itself. It returns one buffer per clock and accepts no input until this is done.

Top module: `rx_chain_mgr`

## Requirements
- R1: After reset the free list holds all NUM_BUFS indices in the order 0, 1, ..., NUM_BUFS-1, `free_level_o` equals NUM_BUFS, the completion queue is empty and `in_ready_o` is high.
- R2: A beat accepted with `in_sof_i` while idle takes the index at the front of the free list as the frame's first buffer. Each stored byte `i` of a frame is written one cycle after its beat is accepted, at address `buf*BUF_BYTES + (i mod BUF_BYTES)`, where `buf` is the buffer that holds it.
- R3: When a buffer holds BUF_BYTES bytes and another byte of the same frame is accepted, the next free index is taken and the full buffer's link entry becomes next = new index, last = 0, count = BUF_BYTES. The count field is a plain binary count, so 64 is stored as 64.
- R4: A beat accepted with `in_eof_i` and without `in_err_i` sets the final buffer's link entry to last = 1 with count = bytes in that buffer. It also pushes a completion entry (`fq_head_o` = first buffer, `fq_len_o` = frame byte count), which is visible in the cycle after that beat.
- R5: A frame whose length is an exact multiple k of BUF_BYTES uses exactly k buffers, and no extra buffer is taken from the free list.
- R6: A beat accepted with both `in_eof_i` and `in_err_i` queues no entry. For the next L cycles, where L is the number of buffers in the frame, `in_ready_o` is low, and the frame's buffers go back to the tail of the free list in chain order, one per cycle.
- R7: If a buffer is needed while the free list is empty, the frame is dropped. That byte and all later bytes up to the end-of-frame beat cause no memory write, and no entry is queued. Buffers already taken are then reclaimed as in R6. If the list is already empty at start of frame, nothing is reclaimed and `in_ready_o` stays high.
- R8: If the completion queue already holds FQ_DEPTH entries when a clean end-of-frame beat is accepted, the frame is reclaimed as in R6 and the queue is unchanged.
- R9: Beats without `in_sof_i` accepted while idle cause no memory write and take no buffer.
- R10: A cycle with `rel_valid_i` high appends `rel_idx_i` to the tail of the free list. A cycle with `fq_pop_i` high and a queue entry present removes the front entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Byte beat valid |
| in_data_i | input | DATA_W | Byte value |
| in_sof_i | input | 1 | Beat is the first of a frame |
| in_eof_i | input | 1 | Beat is the last of a frame |
| in_err_i | input | 1 | Frame is bad (sampled with the end beat) |
| in_ready_o | output | 1 | Beat accepted when high; low while reclaiming |
| rel_valid_i | input | 1 | Return one buffer index to the free list |
| rel_idx_i | input | IDX_W | Returned buffer index |
| free_level_o | output | LVL_W | Number of indices in the free list |
| fq_valid_o | output | 1 | Completion queue not empty |
| fq_head_o | output | IDX_W | First buffer of the front frame |
| fq_len_o | output | LEN_W | Byte length of the front frame |
| fq_pop_i | input | 1 | Remove the front completion entry |
| lnk_idx_i | input | IDX_W | Link table read index |
| lnk_next_o | output | IDX_W | Next buffer of the read entry |
| lnk_last_o | output | 1 | Read entry is the last buffer of its frame |
| lnk_cnt_o | output | CNT_W | Valid bytes in the read buffer |
| mem_we_o | output | 1 | Frame memory write strobe |
| mem_addr_o | output | ADDR_W | Frame memory byte address |
| mem_wdata_o | output | DATA_W | Frame memory write data |

## Verification
Clean frames of every length from 1 to 130 bytes are sent, plus 256 and 1024 bytes. This covers one-buffer frames, the exact 64- and 128-byte boundaries where no spare buffer may be taken, and lengths that just cross a boundary. Each frame is checked write by write, and its link chain is then walked through the read port. Error frames of one, two and four buffers show that the reclaim takes one cycle per buffer. The allocation order of later frames also shows that the reclaimed buffers went to the tail of the free list in chain order. Three further patterns separate the drop paths: the pool runs out mid-frame, the pool is empty at start of frame, and the completion queue is full at a clean end.

// File: rtl/rx_chain_pkg.sv
package rx_chain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DROP,
    ST_RECLAIM
  } rx_state_e;
endpackage

// File: rtl/rx_free_list.sv
module rx_free_list #(
  parameter int unsigned NUM = 16,
  parameter int unsigned IW  = $clog2(NUM),
  parameter int unsigned LW  = $clog2(NUM + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  output logic [IW-1:0] head_o,
  output logic          empty_o,
  input  logic          push_a_i,
  input  logic [IW-1:0] push_a_idx_i,
  input  logic          push_b_i,
  input  logic [IW-1:0] push_b_idx_i,
  output logic [LW-1:0] level_o
);
  logic [IW-1:0] slot_q [NUM];
  logic [IW-1:0] rd_q, wr_q, wr_nx;
  logic [LW-1:0] level_q;

  function automatic logic [IW-1:0] nx(input logic [IW-1:0] p);
    return (p == IW'(NUM - 1)) ? '0 : p + 1'b1;
  endfunction

  assign wr_nx   = nx(wr_q);
  assign head_o  = slot_q[rd_q];
  assign empty_o = (level_q == '0);
  assign level_o = level_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM; i++) slot_q[i] <= IW'(i);
      rd_q    <= '0;
      wr_q    <= '0;
      level_q <= LW'(NUM);
    end else begin
      if (push_a_i) slot_q[wr_q] <= push_a_idx_i;
      if (push_b_i) slot_q[push_a_i ? wr_nx : wr_q] <= push_b_idx_i;
      if (pop_i) rd_q <= nx(rd_q);
      if (push_a_i && push_b_i) wr_q <= nx(wr_nx);
      else if (push_a_i || push_b_i) wr_q <= wr_nx;
      level_q <= level_q + LW'(push_a_i) + LW'(push_b_i) - LW'(pop_i);
    end
  end
endmodule

// File: rtl/rx_link_table.sv
module rx_link_table #(
  parameter int unsigned NUM = 16,
  parameter int unsigned IW  = $clog2(NUM),
  parameter int unsigned EW  = IW + 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wa_en_i,
  input  logic [IW-1:0] wa_idx_i,
  input  logic [EW-1:0] wa_data_i,
  input  logic          wb_en_i,
  input  logic [IW-1:0] wb_idx_i,
  input  logic [EW-1:0] wb_data_i,
  input  logic [IW-1:0] ra_idx_i,
  output logic [EW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [IW-1:0] rb_next_o
);
  logic [EW-1:0] ent_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ent_q[g] <= '0;
      else if (wb_en_i && wb_idx_i == IW'(g)) ent_q[g] <= wb_data_i;
      else if (wa_en_i && wa_idx_i == IW'(g)) ent_q[g] <= wa_data_i;
    end
  end

  assign ra_data_o = ent_q[ra_idx_i];
  assign rb_next_o = ent_q[rb_idx_i][EW-1 -: IW];
endmodule

// File: rtl/rx_sync_fifo.sv
module rx_sync_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] nx(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign data_o  = slot_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) begin
        slot_q[wr_q] <= data_i;
        wr_q         <= nx(wr_q);
      end
      if (do_pop) rd_q <= nx(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/rx_chain_mgr.sv
module rx_chain_mgr #(
  parameter int unsigned NUM_BUFS  = 16,
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned FQ_DEPTH  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_BUFS),
  localparam int unsigned OFF_W  = $clog2(BUF_BYTES),
  localparam int unsigned CNT_W  = $clog2(BUF_BYTES + 1),
  localparam int unsigned LEN_W  = $clog2(NUM_BUFS * BUF_BYTES + 1),
  localparam int unsigned LVL_W  = $clog2(NUM_BUFS + 1),
  localparam int unsigned ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_eof_i,
  input  logic              in_err_i,
  output logic              in_ready_o,
  input  logic              rel_valid_i,
  input  logic [IDX_W-1:0]  rel_idx_i,
  output logic [LVL_W-1:0]  free_level_o,
  output logic              fq_valid_o,
  output logic [IDX_W-1:0]  fq_head_o,
  output logic [LEN_W-1:0]  fq_len_o,
  input  logic              fq_pop_i,
  input  logic [IDX_W-1:0]  lnk_idx_i,
  output logic [IDX_W-1:0]  lnk_next_o,
  output logic              lnk_last_o,
  output logic [CNT_W-1:0]  lnk_cnt_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  import rx_chain_pkg::*;

  localparam int unsigned ENT_W = IDX_W + 1 + CNT_W;
  localparam int unsigned FQ_W  = IDX_W + LEN_W;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BUF_BYTES);

  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  cur_q, cur_d, head_q, head_d, rc_q, rc_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0]  total_q, total_d;
  logic              chain_q, chain_d;

  logic              accept, store;
  logic              fl_pop, fl_empty, rc_push;
  logic [IDX_W-1:0]  fl_head, rc_next;
  logic              la_en, lb_en;
  logic [ENT_W-1:0]  la_data, lb_data, lnk_rd;
  logic              fq_push, fq_full, fq_empty;
  logic [FQ_W-1:0]   fq_rd;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [OFF_W-1:0]  wr_off;

  logic              mem_we_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [DATA_W-1:0] mem_wdata_q;

  assign in_ready_o = (state_q != ST_RECLAIM);
  assign accept     = in_valid_i && in_ready_o;

  rx_free_list #(.NUM(NUM_BUFS), .IW(IDX_W), .LW(LVL_W)) u_free (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (fl_pop),
    .head_o      (fl_head),
    .empty_o     (fl_empty),
    .push_a_i    (rc_push),
    .push_a_idx_i(rc_q),
    .push_b_i    (rel_valid_i),
    .push_b_idx_i(rel_idx_i),
    .level_o     (free_level_o)
  );

  rx_link_table #(.NUM(NUM_BUFS), .IW(IDX_W), .EW(ENT_W)) u_link (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wa_en_i  (la_en),
    .wa_idx_i (cur_q),
    .wa_data_i(la_data),
    .wb_en_i  (lb_en),
    .wb_idx_i (cur_d),
    .wb_data_i(lb_data),
    .ra_idx_i (lnk_idx_i),
    .ra_data_o(lnk_rd),
    .rb_idx_i (rc_q),
    .rb_next_o(rc_next)
  );

  rx_sync_fifo #(.DEPTH(FQ_DEPTH), .W(FQ_W)) u_fq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (fq_push),
    .data_i ({head_d, total_d}),
    .pop_i  (fq_pop_i),
    .data_o (fq_rd),
    .empty_o(fq_empty),
    .full_o (fq_full)
  );

  assign fq_valid_o = !fq_empty;
  assign fq_head_o  = fq_rd[FQ_W-1 -: IDX_W];
  assign fq_len_o   = fq_rd[LEN_W-1:0];
  assign lnk_next_o = lnk_rd[ENT_W-1 -: IDX_W];
  assign lnk_last_o = lnk_rd[CNT_W];
  assign lnk_cnt_o  = lnk_rd[CNT_W-1:0];

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    head_d  = head_q;
    cnt_d   = cnt_q;
    total_d = total_q;
    rc_d    = rc_q;
    chain_d = chain_q;
    fl_pop  = 1'b0;
    rc_push = 1'b0;
    la_en   = 1'b0;
    la_data = '0;
    lb_en   = 1'b0;
    lb_data = '0;
    fq_push = 1'b0;
    wr_en   = 1'b0;
    wr_idx  = cur_q;
    wr_off  = '0;
    store   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && in_sof_i) begin
          if (fl_empty) begin
            chain_d = 1'b0;
            if (!in_eof_i) state_d = ST_DROP;
          end else begin
            fl_pop  = 1'b1;
            cur_d   = fl_head;
            head_d  = fl_head;
            cnt_d   = CNT_W'(1);
            total_d = LEN_W'(1);
            chain_d = 1'b1;
            wr_en   = 1'b1;
            wr_idx  = fl_head;
            store   = 1'b1;
            state_d = ST_RECV;
          end
        end
      end
      ST_RECV: begin
        if (accept) begin
          if (cnt_q == CNT_FULL) begin
            if (fl_empty) begin
              // pool exhausted: drop rest of frame, then reclaim
              rc_d    = head_q;
              state_d = in_eof_i ? ST_RECLAIM : ST_DROP;
            end else begin
              fl_pop  = 1'b1;
              la_en   = 1'b1;
              la_data = {fl_head, 1'b0, CNT_FULL};
              cur_d   = fl_head;
              cnt_d   = CNT_W'(1);
              total_d = total_q + LEN_W'(1);
              wr_en   = 1'b1;
              wr_idx  = fl_head;
              store   = 1'b1;
            end
          end else begin
            wr_en   = 1'b1;
            wr_off  = cnt_q[OFF_W-1:0];
            cnt_d   = cnt_q + CNT_W'(1);
            total_d = total_q + LEN_W'(1);
            store   = 1'b1;
          end
        end
      end
      ST_DROP: begin
        if (accept && in_eof_i) begin
          rc_d    = head_q;
          state_d = chain_q ? ST_RECLAIM : ST_IDLE;
        end
      end
      ST_RECLAIM: begin
        rc_push = 1'b1;
        if (rc_q == cur_q) state_d = ST_IDLE;
        else rc_d = rc_next;
      end
      default: state_d = ST_IDLE;
    endcase

    if (store && in_eof_i) begin
      if (in_err_i || fq_full) begin
        rc_d    = head_d;
        state_d = ST_RECLAIM;
      end else begin
        lb_en   = 1'b1;
        lb_data = {IDX_W'(0), 1'b1, cnt_d};
        fq_push = 1'b1;
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      cur_q       <= '0;
      head_q      <= '0;
      rc_q        <= '0;
      cnt_q       <= '0;
      total_q     <= '0;
      chain_q     <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
    end else begin
      state_q  <= state_d;
      cur_q    <= cur_d;
      head_q   <= head_d;
      rc_q     <= rc_d;
      cnt_q    <= cnt_d;
      total_q  <= total_d;
      chain_q  <= chain_d;
      mem_we_q <= wr_en;
      if (wr_en) begin
        mem_addr_q  <= {wr_idx, wr_off};
        mem_wdata_q <= in_data_i;
      end
    end
  end

  assign mem_we_o    = mem_we_q;
  assign mem_addr_o  = mem_addr_q;
  assign mem_wdata_o = mem_wdata_q;
endmodule

// File: rtl/rx_chain_mgr_chk.sv
module rx_chain_mgr_chk #(
  parameter int unsigned NUM_BUFS  = 16,
  parameter int unsigned BUF_BYTES = 64,
  parameter int unsigned LVL_W     = 5,
  parameter int unsigned LEN_W     = 11,
  parameter int unsigned CNT_W     = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             rel_valid_i,
  input logic [LVL_W-1:0] free_level_o,
  input logic             fq_valid_o,
  input logic [LEN_W-1:0] fq_len_o,
  input logic [CNT_W-1:0] lnk_cnt_o,
  input logic             mem_we_o
);
  p_level_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(free_level_o) <= NUM_BUFS);

  p_write_follows_beat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(in_valid_i && in_ready_o));

  p_link_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(lnk_cnt_o) <= BUF_BYTES);

  p_entry_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fq_valid_o |-> (fq_len_o != '0 && 32'(fq_len_o) <= NUM_BUFS * BUF_BYTES));

  p_reclaim_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> 32'(free_level_o) == 32'($past(free_level_o)) + 1 + 32'($past(rel_valid_i)));

  p_no_write_unready_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_ready_o |=> !mem_we_o);
endmodule

bind rx_chain_mgr rx_chain_mgr_chk #(
  .NUM_BUFS (NUM_BUFS),
  .BUF_BYTES(BUF_BYTES),
  .LVL_W    (LVL_W),
  .LEN_W    (LEN_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .rel_valid_i (rel_valid_i),
  .free_level_o(free_level_o),
  .fq_valid_o  (fq_valid_o),
  .fq_len_o    (fq_len_o),
  .lnk_cnt_o   (lnk_cnt_o),
  .mem_we_o    (mem_we_o)
);

// File: tb/rx_chain_mgr_tb_top.sv
module rx_chain_mgr_tb_top;
  localparam int NB   = 16;
  localparam int BB   = 64;
  localparam int DW   = 8;
  localparam int FQD  = 4;
  localparam int IW   = $clog2(NB);
  localparam int OW   = $clog2(BB);
  localparam int CW   = $clog2(BB + 1);
  localparam int LW   = $clog2(NB * BB + 1);
  localparam int VW   = $clog2(NB + 1);
  localparam int AW   = IW + OW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          rel_valid = 1'b0;
  logic [IW-1:0] rel_idx = '0;
  logic [VW-1:0] free_level;
  logic          fq_valid, fq_pop = 1'b0;
  logic [IW-1:0] fq_head;
  logic [LW-1:0] fq_len;
  logic [IW-1:0] lnk_idx = '0, lnk_next;
  logic          lnk_last;
  logic [CW-1:0] lnk_cnt;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #5 clk = ~clk;

  rx_chain_mgr #(.NUM_BUFS(NB), .BUF_BYTES(BB), .DATA_W(DW), .FQ_DEPTH(FQD)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_sof_i(in_sof), .in_eof_i(in_eof),
    .in_err_i(in_err), .in_ready_o(in_ready),
    .rel_valid_i(rel_valid), .rel_idx_i(rel_idx), .free_level_o(free_level),
    .fq_valid_o(fq_valid), .fq_head_o(fq_head), .fq_len_o(fq_len), .fq_pop_i(fq_pop),
    .lnk_idx_i(lnk_idx), .lnk_next_o(lnk_next), .lnk_last_o(lnk_last), .lnk_cnt_o(lnk_cnt),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int mfree[$];
  int mq_head[$];
  int mq_len[$];
  int pend_rel[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // send one frame; starts and ends at a negedge
  task automatic send_frame(input int len, input bit bad, input int seed);
    int chain[$];
    bit ovr = 0;
    bit stored;
    string tag;
    for (int i = 0; i < len; i++) begin
      bit exp_we = 0;
      int exp_addr = 0;
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_eof   = (i == len - 1);
      in_err   = bad && (i == len - 1);
      in_data  = DW'(seed + i * 7);
      if (!ovr && (i % BB) == 0) begin
        if (mfree.size() == 0) ovr = 1;
        else chain.push_back(mfree.pop_front());
      end
      if (!ovr) begin
        exp_we = 1;
        exp_addr = chain[chain.size() - 1] * BB + (i % BB);
      end
      tag = ovr ? "R7" : ((i >= BB) ? "R3" : "R2");
      step();
      chk(mem_we == exp_we, tag, int'(mem_we), int'(exp_we));
      if (exp_we && mem_we) begin
        chk(int'(mem_addr) == exp_addr, tag, int'(mem_addr), exp_addr);
        chk(mem_wdata == DW'(seed + i * 7), tag, int'(mem_wdata), (seed + i * 7) & 255);
      end
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
    stored = !ovr && !bad && (mq_head.size() < FQD);
    if (stored) begin
      mq_head.push_back(chain[0]);
      mq_len.push_back(len);
      chk(fq_valid == 1'b1, "R4", int'(fq_valid), 1);
      chk(int'(fq_head) == mq_head[0], "R4", int'(fq_head), mq_head[0]);
      chk(int'(fq_len) == mq_len[0], "R4", int'(fq_len), mq_len[0]);
      if (len % BB == 0) chk(chain.size() == len / BB, "R5", chain.size(), len / BB);
      for (int k = 0; k < chain.size(); k++) begin
        lnk_idx = IW'(chain[k]);
        #1;
        if (k < chain.size() - 1) begin
          chk(int'(lnk_next) == chain[k + 1], "R3", int'(lnk_next), chain[k + 1]);
          chk(lnk_last == 1'b0, "R3", int'(lnk_last), 0);
          chk(int'(lnk_cnt) == BB, "R3", int'(lnk_cnt), BB);
        end else begin
          chk(lnk_last == 1'b1, "R4", int'(lnk_last), 1);
          chk(int'(lnk_cnt) == len - k * BB, "R4", int'(lnk_cnt), len - k * BB);
        end
        pend_rel.push_back(chain[k]);
      end
    end else if (chain.size() > 0) begin
      tag = ovr ? "R7" : (bad ? "R6" : "R8");
      for (int k = 0; k < chain.size(); k++) begin
        chk(in_ready == 1'b0, tag, int'(in_ready), 0);
        step();
      end
      chk(in_ready == 1'b1, tag, int'(in_ready), 1);
      for (int k = 0; k < chain.size(); k++) mfree.push_back(chain[k]);
    end else begin
      chk(in_ready == 1'b1, "R7", int'(in_ready), 1);
    end
    chk(int'(free_level) == mfree.size(), stored ? "R5" : "R6", int'(free_level), mfree.size());
  endtask

  task automatic drain();
    while (mq_head.size() > 0) begin
      chk(fq_valid == 1'b1, "R10", int'(fq_valid), 1);
      chk(int'(fq_head) == mq_head[0], "R10", int'(fq_head), mq_head[0]);
      chk(int'(fq_len) == mq_len[0], "R10", int'(fq_len), mq_len[0]);
      void'(mq_head.pop_front());
      void'(mq_len.pop_front());
      fq_pop = 1'b1;
      step();
      fq_pop = 1'b0;
    end
    chk(fq_valid == 1'b0, "R10", int'(fq_valid), 0);
    while (pend_rel.size() > 0) begin
      int b = pend_rel.pop_front();
      rel_valid = 1'b1;
      rel_idx = IW'(b);
      mfree.push_back(b);
      step();
    end
    rel_valid = 1'b0;
    chk(int'(free_level) == mfree.size(), "R10", int'(free_level), mfree.size());
  endtask

  initial begin
    for (int i = 0; i < NB; i++) mfree.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(int'(free_level) == NB, "R1", int'(free_level), NB);
    chk(fq_valid == 1'b0, "R1", int'(fq_valid), 0);
    chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
    // R9 stray beats while idle
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = DW'(i + 9); in_eof = (i == 2);
      step();
      chk(mem_we == 1'b0, "R9", int'(mem_we), 0);
    end
    in_valid = 1'b0; in_eof = 1'b0;
    chk(int'(free_level) == NB, "R9", int'(free_level), NB);
    // R1 order: first frame takes index 0
    send_frame(1, 0, 3);
    chk(pend_rel.size() > 0 && pend_rel[0] == 0, "R1", pend_rel.size() > 0 ? pend_rel[0] : -1, 0);
    drain();
    // clean length sweep
    for (int len = 1; len <= 130; len++) begin
      send_frame(len, 0, len * 3);
      drain();
    end
    send_frame(256, 0, 11);
    drain();
    send_frame(NB * BB, 0, 5);
    drain();
    // error frames
    send_frame(1, 1, 21);
    send_frame(64, 1, 22);
    send_frame(65, 1, 23);
    send_frame(200, 1, 24);
    send_frame(70, 0, 25);
    drain();
    // pool exhausted mid-frame
    for (int f = 0; f < 3; f++) send_frame(256, 0, 40 + f);
    send_frame(300, 0, 50);
    drain();
    // completion queue full
    for (int f = 0; f < FQD; f++) send_frame(1, 0, 60 + f);
    send_frame(1, 0, 70);
    drain();
    // pool empty at start of frame
    for (int f = 0; f < FQD; f++) send_frame(256, 0, 80 + f);
    send_frame(10, 0, 90);
    drain();
    send_frame(130, 0, 95);
    drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule